// File: doc/BRIEF.md
# Multi-Tick Accumulator Processor Core

This block is a 16-bit accumulator processor. It holds a program counter, an instruction register, an accumulator and an indirect address register. It reaches a shared word memory through an address bus, a data bus, an enable line and a read/write line. The address and data bus directions are given as separate drive-enable outputs, so the block has no tri-state pins. Each instruction is a fetch followed by an execute phase. A small tick counter restarts at zero on entry to every phase and steps through that phase's handshake.

Bus strobes change only on falling clock edges. Register contents change only on rising edges. This gives the memory half a cycle of setup on each side of a strobe. A store lowers the write strobe only after its address is stable, and raises it again before the address is released.

A proceed input lets an external single-step controller hold the core after any fetch. Execution resumes when proceed is seen high.

Top module: `acc_cpu`

## Requirements
- R1: A read cycle drives enable=1, rw=1 and a valid address (addr_drive=1). Enable is never high without the address being driven. Every strobe output changes only on a falling clock edge.
- R2: The fetch takes three ticks. Enable and address=PC are raised at the falling edge of tick 0 and dropped at the falling edge of tick 2. IREG captures the data bus at the rising edge that ends tick 1. At the rising edge that ends tick 2, PC increments by one and execution is entered.
- R3: The opcode is IREG[15:12] and the operand is IREG[11:0]. Opcode 1 loads the zero-extended operand into ACC. Opcode 6 loads the zero-extended operand into PC. Opcode 7 does the same only when ACC is zero. Each of these takes a single tick and uses no bus cycle.
- R4: Opcodes 2 (load), A (add, modulo 2^16) and D (bitwise and) read address {4'h0, operand}. Enable is up from the falling edge of tick 0 to the falling edge of tick 2. ACC takes the data word, or ACC op data, at the rising edge ending tick 1. The instruction ends after tick 2.
- R5: Opcode 4 (direct store) raises enable and the address at tick 0. It lowers rw and drives ACC on the data bus at tick 1, raises rw at tick 3, and releases both buses at tick 4, all on falling edges. While rw is low, the address and write data stay constant.
- R6: Opcode 5 (indirect store) reads {4'h0, operand} and latches the word into IAR at the end of tick 1. It drops enable at tick 2 and re-raises it with address=IAR at tick 3. It lowers rw and drives ACC at tick 4, raises rw at tick 6, and releases the buses at tick 7.
- R7: Opcode 3 (indirect load) reads the pointer like R6 through tick 3. ACC takes the data read from IAR at the end of tick 4. Enable drops at tick 5 and the instruction ends there.
- R8: While rst is high, the outputs are enable=0, rw=1, addr_drive=0 and data_drive=0, and all registers clear. On the first rising edge with rst low the core enters fetch, and it fetches from address 0.
- R9: Opcode 0 and every opcode not listed above halt the core. A halted core makes no bus activity until the next reset.
- R10: If proceed is low at the rising edge ending fetch tick 2, the core waits with the buses idle. It enters execute on the first rising edge at which proceed is high. PC has already been incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proceed | input | 1 | High lets a fetched instruction start executing |
| mem_rdata | input | 16 | Word returned by memory during a read |
| mem_en | output | 1 | Memory enable |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | 16 | Address bus value |
| addr_drive | output | 1 | Address bus is driven by the core |
| mem_wdata | output | 16 | Write data bus value |
| data_drive | output | 1 | Write data bus is driven by the core |

## Verification
One program uses every opcode once or more. It covers a taken and a not-taken conditional branch, an unconditional jump, and a pointer-based load and store. The stores that a taken branch must skip land on sentinel words, so a branch that falls through is told apart from one that jumps. The first run starts with proceed held low, which separates a core that pauses after the fetch from one that runs on. A second run after a mid-stream reset ends on an undefined opcode, which tells a true halt apart from a core that treats unknown codes as no-ops. A behavioural model predicts every strobe level in every cycle, so a strobe that is one tick early or late shows up as a mismatch.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [3:0] {
    ST_RESET, ST_FETCH, ST_PAUSE, ST_HALT,
    ST_LDI, ST_LDD, ST_LDX, ST_STD, ST_STX,
    ST_JMP, ST_JZ, ST_ADD, ST_AND
  } state_t;

  function automatic state_t decode_op(input logic [OP_W-1:0] op);
    case (op)
      4'h1:    return ST_LDI;
      4'h2:    return ST_LDD;
      4'h3:    return ST_LDX;
      4'h4:    return ST_STD;
      4'h5:    return ST_STX;
      4'h6:    return ST_JMP;
      4'h7:    return ST_JZ;
      4'hA:    return ST_ADD;
      4'hD:    return ST_AND;
      default: return ST_HALT;
    endcase
  endfunction
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int WIDTH = 16
) (
  input  logic             sel_and,
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic [WIDTH-1:0] result
);
  always_comb begin
    if (sel_and) result = lhs & rhs;
    else         result = lhs + rhs;
  end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int TICK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proceed,
  input  logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  alu_res,
  output state_t            state,
  output logic [TICK_W-1:0] tick,
  output logic [WIDTH-1:0]  pc,
  output logic [WIDTH-1:0]  ireg,
  output logic [WIDTH-1:0]  acc,
  output logic [WIDTH-1:0]  iar
);
  localparam int OPERAND_W = WIDTH - OP_W;

  logic [WIDTH-1:0] imm;
  state_t           entry;

  assign imm   = {{OP_W{1'b0}}, ireg[OPERAND_W-1:0]};
  assign entry = decode_op(ireg[WIDTH-1 -: OP_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RESET;
      tick  <= '0;
      pc    <= '0;
      ireg  <= '0;
      acc   <= '0;
      iar   <= '0;
    end else begin
      tick <= tick + TICK_W'(1);
      case (state)
        ST_RESET: begin
          state <= ST_FETCH;
          tick  <= '0;
        end
        ST_FETCH: begin
          if (tick == TICK_W'(1)) ireg <= rdata;
          if (tick == TICK_W'(2)) begin
            pc    <= pc + WIDTH'(1);
            tick  <= '0;
            state <= proceed ? entry : ST_PAUSE;
          end
        end
        ST_PAUSE: begin
          tick <= '0;
          if (proceed) state <= entry;
        end
        ST_HALT: tick <= '0;
        ST_LDI: begin
          acc   <= imm;
          state <= ST_FETCH;
          tick  <= '0;
        end
        ST_JMP: begin
          pc    <= imm;
          state <= ST_FETCH;
          tick  <= '0;
        end
        ST_JZ: begin
          if (acc == '0) pc <= imm;
          state <= ST_FETCH;
          tick  <= '0;
        end
        ST_LDD, ST_ADD, ST_AND: begin
          if (tick == TICK_W'(1)) acc <= (state == ST_LDD) ? rdata : alu_res;
          if (tick == TICK_W'(2)) begin
            state <= ST_FETCH;
            tick  <= '0;
          end
        end
        ST_LDX: begin
          if (tick == TICK_W'(1)) iar <= rdata;
          if (tick == TICK_W'(4)) acc <= rdata;
          if (tick == TICK_W'(5)) begin
            state <= ST_FETCH;
            tick  <= '0;
          end
        end
        ST_STD: begin
          if (tick == TICK_W'(4)) begin
            state <= ST_FETCH;
            tick  <= '0;
          end
        end
        ST_STX: begin
          if (tick == TICK_W'(1)) iar <= rdata;
          if (tick == TICK_W'(7)) begin
            state <= ST_FETCH;
            tick  <= '0;
          end
        end
        default: begin
          state <= ST_HALT;
          tick  <= '0;
        end
      endcase
    end
  end

  // R2
  fetch_ireg_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && tick == TICK_W'(1)) |=> (ireg == $past(rdata)));

  // R2
  fetch_pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && tick == TICK_W'(2)) |=> (pc == $past(pc) + WIDTH'(1)));

  // R3
  imm_load_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LDI) |=> (acc == $past(imm) && state == ST_FETCH));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT) |=> (state == ST_HALT));

  // R10
  pause_on_low_proceed_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && tick == TICK_W'(2) && !proceed) |=> (state == ST_PAUSE));
endmodule

// File: rtl/acc_cpu_bus.sv
module acc_cpu_bus
  import acc_cpu_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int TICK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  state_t            state,
  input  logic [TICK_W-1:0] tick,
  input  logic [WIDTH-1:0]  pc,
  input  logic [WIDTH-1:0]  dir_addr,
  input  logic [WIDTH-1:0]  acc,
  input  logic [WIDTH-1:0]  iar,
  output logic              mem_en,
  output logic              mem_rw,
  output logic [WIDTH-1:0]  mem_addr,
  output logic              addr_drive,
  output logic [WIDTH-1:0]  mem_wdata,
  output logic              data_drive
);
  always_ff @(negedge clk) begin
    if (rst) begin
      mem_en     <= 1'b0;
      mem_rw     <= 1'b1;
      mem_addr   <= '0;
      addr_drive <= 1'b0;
      mem_wdata  <= '0;
      data_drive <= 1'b0;
    end else begin
      case (state)
        ST_FETCH, ST_LDD, ST_ADD, ST_AND: begin
          if (tick == TICK_W'(0)) begin
            mem_en     <= 1'b1;
            addr_drive <= 1'b1;
            mem_addr   <= (state == ST_FETCH) ? pc : dir_addr;
          end
          if (tick == TICK_W'(2)) begin
            mem_en     <= 1'b0;
            addr_drive <= 1'b0;
          end
        end
        ST_LDX, ST_STX: begin
          if (tick == TICK_W'(0)) begin
            mem_en     <= 1'b1;
            addr_drive <= 1'b1;
            mem_addr   <= dir_addr;
          end
          if (tick == TICK_W'(2)) begin
            mem_en     <= 1'b0;
            addr_drive <= 1'b0;
          end
          if (tick == TICK_W'(3)) begin
            mem_en     <= 1'b1;
            addr_drive <= 1'b1;
            mem_addr   <= iar;
          end
          if (state == ST_LDX && tick == TICK_W'(5)) begin
            mem_en     <= 1'b0;
            addr_drive <= 1'b0;
          end
          if (state == ST_STX && tick == TICK_W'(4)) begin
            mem_rw     <= 1'b0;
            data_drive <= 1'b1;
            mem_wdata  <= acc;
          end
          if (state == ST_STX && tick == TICK_W'(6)) mem_rw <= 1'b1;
          if (state == ST_STX && tick == TICK_W'(7)) begin
            mem_en     <= 1'b0;
            addr_drive <= 1'b0;
            data_drive <= 1'b0;
          end
        end
        ST_STD: begin
          if (tick == TICK_W'(0)) begin
            mem_en     <= 1'b1;
            addr_drive <= 1'b1;
            mem_addr   <= dir_addr;
          end
          if (tick == TICK_W'(1)) begin
            mem_rw     <= 1'b0;
            data_drive <= 1'b1;
            mem_wdata  <= acc;
          end
          if (tick == TICK_W'(3)) mem_rw <= 1'b1;
          if (tick == TICK_W'(4)) begin
            mem_en     <= 1'b0;
            addr_drive <= 1'b0;
            data_drive <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  enable_drives_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> addr_drive);

  // R5
  write_needs_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_rw |-> (mem_en && addr_drive && data_drive));

  // R5
  write_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_rw && $past(!mem_rw)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  // R9
  halt_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT && $past(state == ST_HALT)) |-> (!mem_en && mem_rw));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int TICK_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             proceed,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic             mem_en,
  output logic             mem_rw,
  output logic [WIDTH-1:0] mem_addr,
  output logic             addr_drive,
  output logic [WIDTH-1:0] mem_wdata,
  output logic             data_drive
);
  localparam int OPERAND_W = WIDTH - OP_W;

  state_t            state;
  logic [TICK_W-1:0] tick;
  logic [WIDTH-1:0]  pc, ireg, acc, iar, alu_res, dir_addr;

  assign dir_addr = {{OP_W{1'b0}}, ireg[OPERAND_W-1:0]};

  acc_cpu_alu #(.WIDTH(WIDTH)) u_alu (
    .sel_and (state == ST_AND),
    .lhs     (acc),
    .rhs     (mem_rdata),
    .result  (alu_res)
  );

  acc_cpu_seq #(.WIDTH(WIDTH), .TICK_W(TICK_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .proceed (proceed),
    .rdata   (mem_rdata),
    .alu_res (alu_res),
    .state   (state),
    .tick    (tick),
    .pc      (pc),
    .ireg    (ireg),
    .acc     (acc),
    .iar     (iar)
  );

  acc_cpu_bus #(.WIDTH(WIDTH), .TICK_W(TICK_W)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .tick       (tick),
    .pc         (pc),
    .dir_addr   (dir_addr),
    .acc        (acc),
    .iar        (iar),
    .mem_en     (mem_en),
    .mem_rw     (mem_rw),
    .mem_addr   (mem_addr),
    .addr_drive (addr_drive),
    .mem_wdata  (mem_wdata),
    .data_drive (data_drive)
  );
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  localparam int P = 10;

  localparam int M_RESET = 0, M_FETCH = 1, M_PAUSE = 2, M_HALT = 3, M_LDI = 4,
                 M_LDD = 5, M_LDX = 6, M_STD = 7, M_STX = 8, M_JMP = 9,
                 M_JZ = 10, M_ADD = 11, M_AND = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        proceed = 1'b0;
  logic [15:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_en, mem_rw, addr_drive, data_drive;

  logic [15:0] dut_mem [0:255];
  logic [15:0] ref_mem [0:255];

  int checks = 0;
  int errors = 0;

  // behavioural model state
  int          m_state = M_RESET;
  int          m_tick = 0;
  logic [15:0] m_pc = 0, m_ireg = 0, m_acc = 0, m_iar = 0;
  logic        m_en = 0, m_rw = 1, m_aoe = 0, m_doe = 0;
  logic [15:0] m_addr = 0, m_wd = 0;
  logic        m_valid = 0;
  logic        s_rst = 1, s_proceed = 0;

  acc_cpu uut (
    .clk        (clk),
    .rst        (rst),
    .proceed    (proceed),
    .mem_rdata  (mem_rdata),
    .mem_en     (mem_en),
    .mem_rw     (mem_rw),
    .mem_addr   (mem_addr),
    .addr_drive (addr_drive),
    .mem_wdata  (mem_wdata),
    .data_drive (data_drive)
  );

  always #(P/2) clk = ~clk;

  assign mem_rdata = (mem_en === 1'b1 && mem_rw === 1'b1) ? dut_mem[mem_addr[7:0]] : 16'h0;

  always @(posedge clk) begin
    if (rst === 1'b0 && mem_en === 1'b1 && mem_rw === 1'b0)
      dut_mem[mem_addr[7:0]] <= mem_wdata;
  end

  function automatic int dec(input logic [3:0] op);
    case (op)
      4'h1: return M_LDI;
      4'h2: return M_LDD;
      4'h3: return M_LDX;
      4'h4: return M_STD;
      4'h5: return M_STX;
      4'h6: return M_JMP;
      4'h7: return M_JZ;
      4'hA: return M_ADD;
      4'hD: return M_AND;
      default: return M_HALT;
    endcase
  endfunction

  function automatic string tag_of(input int st);
    case (st)
      M_RESET: return "R8";
      M_FETCH: return "R2";
      M_PAUSE: return "R10";
      M_HALT:  return "R9";
      M_LDI, M_JMP, M_JZ: return "R3";
      M_LDD, M_ADD, M_AND: return "R4";
      M_STD:   return "R5";
      M_STX:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic open_bus(input logic [15:0] a);
    m_en = 1; m_aoe = 1; m_addr = a;
  endtask

  task automatic close_bus();
    m_en = 0; m_aoe = 0;
  endtask

  task automatic model_fall();
    logic [15:0] dir;
    dir = {4'h0, m_ireg[11:0]};
    if (rst) begin
      m_en = 0; m_rw = 1; m_aoe = 0; m_doe = 0; m_addr = 0; m_wd = 0;
      m_valid = 1;
      return;
    end
    case (m_state)
      M_FETCH, M_LDD, M_ADD, M_AND: begin
        if (m_tick == 0) open_bus(m_state == M_FETCH ? m_pc : dir);
        if (m_tick == 2) close_bus();
      end
      M_LDX: begin
        if (m_tick == 0) open_bus(dir);
        if (m_tick == 2) close_bus();
        if (m_tick == 3) open_bus(m_iar);
        if (m_tick == 5) close_bus();
      end
      M_STD: begin
        if (m_tick == 0) open_bus(dir);
        if (m_tick == 1) begin m_rw = 0; m_doe = 1; m_wd = m_acc; end
        if (m_tick == 3) m_rw = 1;
        if (m_tick == 4) begin close_bus(); m_doe = 0; end
      end
      M_STX: begin
        if (m_tick == 0) open_bus(dir);
        if (m_tick == 2) close_bus();
        if (m_tick == 3) open_bus(m_iar);
        if (m_tick == 4) begin m_rw = 0; m_doe = 1; m_wd = m_acc; end
        if (m_tick == 6) m_rw = 1;
        if (m_tick == 7) begin close_bus(); m_doe = 0; end
      end
      default: ;
    endcase
  endtask

  task automatic model_rise();
    logic [15:0] imm, data;
    int nt;
    imm  = {4'h0, m_ireg[11:0]};
    data = (m_en && m_rw) ? ref_mem[m_addr[7:0]] : 16'h0;
    if (s_rst) begin
      m_state = M_RESET; m_tick = 0;
      m_pc = 0; m_ireg = 0; m_acc = 0; m_iar = 0;
      return;
    end
    if (m_en && !m_rw) ref_mem[m_addr[7:0]] = m_wd;
    nt = m_tick + 1;
    case (m_state)
      M_RESET: begin m_state = M_FETCH; nt = 0; end
      M_FETCH: begin
        if (m_tick == 1) m_ireg = data;
        if (m_tick == 2) begin
          m_pc = m_pc + 1; nt = 0;
          m_state = s_proceed ? dec(m_ireg[15:12]) : M_PAUSE;
        end
      end
      M_PAUSE: begin nt = 0; if (s_proceed) m_state = dec(m_ireg[15:12]); end
      M_HALT:  nt = 0;
      M_LDI:   begin m_acc = imm; m_state = M_FETCH; nt = 0; end
      M_JMP:   begin m_pc = imm; m_state = M_FETCH; nt = 0; end
      M_JZ:    begin if (m_acc == 0) m_pc = imm; m_state = M_FETCH; nt = 0; end
      M_LDD, M_ADD, M_AND: begin
        if (m_tick == 1)
          m_acc = (m_state == M_LDD) ? data : (m_state == M_ADD) ? m_acc + data : m_acc & data;
        if (m_tick == 2) begin m_state = M_FETCH; nt = 0; end
      end
      M_LDX: begin
        if (m_tick == 1) m_iar = data;
        if (m_tick == 4) m_acc = data;
        if (m_tick == 5) begin m_state = M_FETCH; nt = 0; end
      end
      M_STD: if (m_tick == 4) begin m_state = M_FETCH; nt = 0; end
      M_STX: begin
        if (m_tick == 1) m_iar = data;
        if (m_tick == 7) begin m_state = M_FETCH; nt = 0; end
      end
      default: ;
    endcase
    m_tick = nt;
  endtask

  task automatic compare_bus();
    string t;
    t = tag_of(m_state);
    check(t, "mem_en", {15'h0, mem_en}, {15'h0, m_en});
    check(t, "mem_rw", {15'h0, mem_rw}, {15'h0, m_rw});
    check(t, "addr_drive", {15'h0, addr_drive}, {15'h0, m_aoe});
    check(t, "data_drive", {15'h0, data_drive}, {15'h0, m_doe});
    if (m_aoe) check(t, "mem_addr", mem_addr, m_addr);
    if (m_doe) check(t, "mem_wdata", mem_wdata, m_wd);
  endtask

  always @(negedge clk) begin
    #1;
    model_fall();
    #(P/2 - 3);
    if (m_valid) compare_bus();
    s_rst = rst;
    s_proceed = proceed;
  end

  always @(posedge clk) begin
    #1;
    model_rise();
  end

  task automatic put(input int a, input logic [15:0] v);
    dut_mem[a] = v;
    ref_mem[a] = v;
  endtask

  task automatic load_program();
    for (int i = 0; i < 256; i++) put(i, 16'h0);
    put(8'h00, 16'h1005); // ACC = 5
    put(8'h01, 16'h4040); // M40 = 5
    put(8'h02, 16'hA041); // ACC = 5 + 3
    put(8'h03, 16'hD042); // ACC = 8 & C
    put(8'h04, 16'h4043); // M43 = 8
    put(8'h05, 16'h2044); // ACC = 1234
    put(8'h06, 16'h5045); // M[M45] = 1234
    put(8'h07, 16'h3046); // ACC = M[M46] = 3
    put(8'h08, 16'h4047); // M47 = 3
    put(8'h09, 16'h1000); // ACC = 0
    put(8'h0A, 16'h700C); // taken
    put(8'h0B, 16'h4048); // skipped
    put(8'h0C, 16'h1007); // ACC = 7
    put(8'h0D, 16'h7010); // not taken
    put(8'h0E, 16'h4049); // M49 = 7
    put(8'h0F, 16'h6011); // jump
    put(8'h10, 16'h404A); // skipped
    put(8'h11, 16'h0000); // halt
    put(8'h41, 16'h0003);
    put(8'h42, 16'h000C);
    put(8'h44, 16'h1234);
    put(8'h45, 16'h0050);
    put(8'h46, 16'h0041);
    put(8'h48, 16'hFFFF);
    put(8'h4A, 16'hFFFF);
  endtask

  task automatic check_results();
    check("R5", "M40 direct store", dut_mem[8'h40], 16'h0005);
    check("R4", "M43 add then and", dut_mem[8'h43], 16'h0008);
    check("R6", "M50 indirect store", dut_mem[8'h50], 16'h1234);
    check("R7", "M47 indirect load", dut_mem[8'h47], 16'h0003);
    check("R3", "M48 skipped by taken zero branch", dut_mem[8'h48], 16'hFFFF);
    check("R3", "M49 after untaken branch", dut_mem[8'h49], 16'h0007);
    check("R3", "M4A skipped by jump", dut_mem[8'h4A], 16'hFFFF);
  endtask

  task automatic check_idle(input string req);
    int busy;
    busy = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #3;
      if (mem_en !== 1'b0) busy++;
    end
    check(req, "enable cycles while halted", 16'(busy), 16'h0);
  endtask

  task automatic check_reset_outputs();
    @(negedge clk); #3;
    check("R8", "reset mem_en", {15'h0, mem_en}, 16'h0);
    check("R8", "reset mem_rw", {15'h0, mem_rw}, 16'h1);
    check("R8", "reset addr_drive", {15'h0, addr_drive}, 16'h0);
    check("R8", "reset data_drive", {15'h0, data_drive}, 16'h0);
  endtask

  initial begin
    int en_cycles;
    load_program();
    rst = 1; proceed = 0;
    repeat (3) @(posedge clk);
    check_reset_outputs();
    @(posedge clk); #2 rst = 0;
    // R10: proceed held low; only the first fetch may touch the bus
    en_cycles = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #3;
      if (i == 1) begin
        check("R8", "first fetch enable", {15'h0, mem_en}, 16'h1);
        check("R8", "first fetch address", mem_addr, 16'h0000);
      end
      if (mem_en === 1'b1) en_cycles++;
    end
    check("R10", "enable cycles while held", 16'(en_cycles), 16'h2);
    @(posedge clk); #2 proceed = 1;
    repeat (300) @(posedge clk);
    check_results();
    check_idle("R9");
    // second run: undefined opcode at the end, fresh result slot
    @(posedge clk); #2;
    put(8'h11, 16'h8123);
    put(8'h40, 16'h0000);
    rst = 1;
    repeat (2) @(posedge clk);
    check_reset_outputs();
    @(posedge clk); #2 rst = 0;
    repeat (300) @(posedge clk);
    check_results();
    check_idle("R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule